// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a bank of peripheral interrupt request lines and one non-maskable request. It brings them into the clock domain and keeps a pending bit for each line. It then decides whether the most urgent eligible request may interrupt whatever the core is running now. Each line has its own enable, its own trigger mode (edge or level) and its own 3-bit priority, where a smaller number is more urgent. One global mask input silences every line except the non-maskable one.

When a request wins and is strictly more urgent than the current execution level, the block raises a take request carrying a vector index. The core accepts it with an acknowledge. At that point the line moves from pending to active, and its level is pushed onto a stack of active levels, so handlers can nest.

A handler-return pulse pops the stack and restores the interrupted level. If a waiting request would win against the restored level, the block pulses a tail-chain flag one cycle later. The core can then go straight to the next handler without unstacking its context. Register stacking and the vector table belong to the core and are not part of this block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A line whose enable bit is 0 is never offered to the core, even while its pending bit is 1.
- R2: A winning request is offered only when its level is strictly smaller (more urgent) than the current execution level. A request of equal or lesser urgency stays pending.
- R3: While the global mask is 1, no maskable line is offered. The non-maskable request is still offered and taken.
- R4: The execution level is 0 for the non-maskable handler, p+1 for a line of priority p, and 2^PRIO_W+1 (9) when idle. After a handler returns, the execution level goes back to the level of the handler it interrupted.
- R5: When a line's trigger bit is 0 (edge mode), its pending bit is set by a synchronised rising edge. It is cleared when the core acknowledges that line, or by a 1 on the line's write-one-to-clear input. A rising edge in the same cycle as a clear wins.
- R6: When a line's trigger bit is 1 (level mode), its pending bit follows the synchronised source while the line is not active. If the source is still high when the handler returns, the line becomes pending again and is taken again.
- R7: tail_chain is a one-cycle pulse, in the cycle after a handler return. It is raised when a pending, enabled and unmasked request (including a still-asserted level line that is returning) is more urgent than the level restored by that return.
- R8: take_vector is the line number 0..N_LINES-1 for a maskable line, and N_LINES (16) for the non-maskable request.
- R9: Among pending lines of equal priority, the lower line number is selected.
- R10: take_vector holds steady while take_valid is 1 and no acknowledge has arrived. On acknowledge, take_valid drops, the selected line becomes active and its pending bit clears.
- R11: An acknowledge that arrives while the stack holds STACK_DEPTH entries sets stack_overflow. The flag stays set until reset, the entry is dropped and the execution level does not change.
- R12: After reset, take_valid, tail_chain, stack_overflow and every pending and active bit are 0, and exec_level is 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Asynchronous request lines |
| nmi_in | input | 1 | Asynchronous non-maskable request (edge) |
| line_en | input | N_LINES | Per-line enable |
| line_trig | input | N_LINES | Per-line trigger mode, 0 edge, 1 level |
| line_prio | input | N_LINES*PRIO_W | Per-line priority, line i at bits [i*PRIO_W +: PRIO_W] |
| mask_all | input | 1 | Global mask for maskable lines |
| pend_clear | input | N_LINES | Write-one-to-clear for edge pending bits |
| take_valid | output | 1 | Take request to the core |
| take_vector | output | $clog2(N_LINES+1) | Vector index of the offered request |
| take_ack | input | 1 | Core accepts the take request |
| handler_ret | input | 1 | Core returns from the current handler |
| tail_chain | output | 1 | Next handler may follow without unstacking |
| exec_level | output | PRIO_W+1 | Current execution level |
| stack_overflow | output | 1 | Sticky active-stack overflow error |
| pend_status | output | N_LINES | Pending bits |
| active_status | output | N_LINES | Active bits |
| nmi_active | output | 1 | Non-maskable handler active |

## Verification
The bench builds the block with 16 lines, 3-bit priorities and two synchroniser stages, matching the defaults, but with STACK_DEPTH set to 4. The shallower stack means five nested levels are enough to reach overflow: four lines of falling priority plus the non-maskable request. A behavioural model with a queue for the level stack runs beside the design and is compared on every clock. Directed sequences cover equal-priority blocking, the same-priority tie, mask versus non-maskable, level re-entry and tail-chain pulses.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    // Width of an execution level: holds 0 (non-maskable), p+1, and idle.
    function automatic int unsigned lvl_width(int unsigned pw);
        return pw + 1;
    endfunction

    // Idle execution level, one past the least urgent line level.
    function automatic int unsigned idle_lvl(int unsigned pw);
        return (1 << pw) + 1;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int unsigned W      = 17,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl_out,
    output logic [W-1:0] rise_out
);

    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
            prev_q <= '0;
        end else begin
            stg_q[0] <= async_in;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
            prev_q <= stg_q[STAGES-1];
        end
    end

    assign lvl_out  = stg_q[STAGES-1];
    assign rise_out = stg_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/irqc_pend.sv
module irqc_pend
    import irqc_pkg::*;
#(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_in,
    input  logic [N-1:0] rise_in,
    input  logic [N-1:0] cfg_level,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ack_mask,
    input  logic [N-1:0] active,
    output logic [N-1:0] pend
);

    for (genvar i = 0; i < N; i++) begin : g_line
        logic line_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                line_q <= 1'b0;
            end else if (cfg_level[i] == TRIG_LEVEL) begin
                line_q <= lvl_in[i] & ~active[i] & ~ack_mask[i];
            end else begin
                line_q <= rise_in[i] | (line_q & ~clr[i] & ~ack_mask[i]);
            end
        end

        assign pend[i] = line_q;

        // R5
        edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_level[i] == TRIG_EDGE && line_q && !clr[i] && !ack_mask[i]) |=> line_q);

        // R6
        level_follow_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_level[i] == TRIG_LEVEL && lvl_in[i] && !active[i] && !ack_mask[i]) |=> line_q);
    end

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
    parameter int unsigned N    = 16,
    parameter int unsigned PW   = 3,
    parameter int unsigned LW   = 4,
    parameter int unsigned VW   = 5,
    parameter int unsigned IDLE = 9
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    input  logic            nmi_req,
    output logic            hit,
    output logic [LW-1:0]   win_lvl,
    output logic [VW-1:0]   win_id
);

    always_comb begin
        hit     = 1'b0;
        win_lvl = LW'(IDLE);
        win_id  = '0;
        // Ascending scan with strict compare: lower index wins a tie.
        for (int i = 0; i < N; i++) begin
            if (req[i] && (LW'(prio[i*PW +: PW]) + LW'(1)) < win_lvl) begin
                hit     = 1'b1;
                win_lvl = LW'(prio[i*PW +: PW]) + LW'(1);
                win_id  = VW'(i);
            end
        end
        if (nmi_req) begin
            hit     = 1'b1;
            win_lvl = '0;
            win_id  = VW'(N);
        end
    end

endmodule

// File: rtl/irqc_stack.sv
module irqc_stack #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LW    = 4,
    parameter int unsigned VW    = 5,
    parameter int unsigned IDLE  = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [LW-1:0] push_lvl,
    input  logic [VW-1:0] push_id,
    input  logic          pop,
    output logic [LW-1:0] top_lvl,
    output logic [VW-1:0] top_id,
    output logic [LW-1:0] below_lvl,
    output logic          empty,
    output logic          overflow
);

    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned IW = $clog2(DEPTH);

    logic [LW-1:0] lvl_q [DEPTH];
    logic [VW-1:0] id_q  [DEPTH];
    logic [CW-1:0] cnt_q;
    logic          ovf_q;
    logic          do_pop;
    logic [CW-1:0] cnt_mid;
    logic [CW-1:0] top_ix;
    logic [CW-1:0] below_ix;

    assign do_pop   = pop && (cnt_q != '0);
    assign cnt_mid  = cnt_q - CW'(do_pop);
    assign top_ix   = cnt_q - CW'(1);
    assign below_ix = cnt_q - CW'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
            for (int k = 0; k < DEPTH; k++) begin
                lvl_q[k] <= '0;
                id_q[k]  <= '0;
            end
        end else if (push) begin
            if (cnt_mid == CW'(DEPTH)) begin
                ovf_q <= 1'b1;
                cnt_q <= cnt_mid;
            end else begin
                lvl_q[cnt_mid[IW-1:0]] <= push_lvl;
                id_q[cnt_mid[IW-1:0]]  <= push_id;
                cnt_q <= cnt_mid + CW'(1);
            end
        end else begin
            cnt_q <= cnt_mid;
        end
    end

    assign empty     = (cnt_q == '0);
    assign top_lvl   = empty ? LW'(IDLE) : lvl_q[top_ix[IW-1:0]];
    assign top_id    = empty ? '0 : id_q[top_ix[IW-1:0]];
    assign below_lvl = (cnt_q < CW'(2)) ? LW'(IDLE) : lvl_q[below_ix[IW-1:0]];
    assign overflow  = ovf_q;

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

    // R11
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R4
    pop_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (do_pop && !push) |=> top_lvl == $past(below_lvl));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned N_LINES     = 16,
    parameter int unsigned PRIO_W      = 3,
    parameter int unsigned STACK_DEPTH = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_LINES-1:0]          irq_in,
    input  logic                        nmi_in,
    input  logic [N_LINES-1:0]          line_en,
    input  logic [N_LINES-1:0]          line_trig,
    input  logic [N_LINES*PRIO_W-1:0]   line_prio,
    input  logic                        mask_all,
    input  logic [N_LINES-1:0]          pend_clear,
    output logic                        take_valid,
    output logic [$clog2(N_LINES+1)-1:0] take_vector,
    input  logic                        take_ack,
    input  logic                        handler_ret,
    output logic                        tail_chain,
    output logic [PRIO_W:0]             exec_level,
    output logic                        stack_overflow,
    output logic [N_LINES-1:0]          pend_status,
    output logic [N_LINES-1:0]          active_status,
    output logic                        nmi_active
);

    localparam int unsigned VEC_W  = $clog2(N_LINES + 1);
    localparam int unsigned LINE_W = $clog2(N_LINES);
    localparam int unsigned LVL_W  = lvl_width(PRIO_W);
    localparam int unsigned IDLE   = idle_lvl(PRIO_W);

    // Synchronised sources, non-maskable request in the top bit.
    logic [N_LINES:0] src_lvl, src_rise;

    irqc_sync #(.W(N_LINES + 1), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .async_in({nmi_in, irq_in}),
        .lvl_out(src_lvl),
        .rise_out(src_rise)
    );

    logic                 tv_q;
    logic [VEC_W-1:0]     vec_q;
    logic [LVL_W-1:0]     lvl_q;
    logic                 tail_q;
    logic [N_LINES-1:0]   act_q;
    logic                 nmi_act_q;
    logic                 nmi_pend_q;
    logic [N_LINES-1:0]   pend;

    logic                 ack, vec_is_nmi, ack_nmi;
    logic [N_LINES-1:0]   ack_mask;

    assign ack        = tv_q && take_ack;
    assign vec_is_nmi = (vec_q == VEC_W'(N_LINES));
    assign ack_nmi    = ack && vec_is_nmi;
    assign ack_mask   = (ack && !vec_is_nmi) ? (N_LINES'(1) << vec_q[LINE_W-1:0]) : '0;

    irqc_pend #(.N(N_LINES)) u_pend (
        .clk(clk), .rst(rst),
        .lvl_in(src_lvl[N_LINES-1:0]),
        .rise_in(src_rise[N_LINES-1:0]),
        .cfg_level(line_trig),
        .clr(pend_clear),
        .ack_mask(ack_mask),
        .active(act_q),
        .pend(pend)
    );

    // Active-level stack.
    logic [LVL_W-1:0] top_lvl, below_lvl;
    logic [VEC_W-1:0] top_id;
    logic             stk_empty, stk_ovf;

    irqc_stack #(.DEPTH(STACK_DEPTH), .LW(LVL_W), .VW(VEC_W), .IDLE(IDLE)) u_stack (
        .clk(clk), .rst(rst),
        .push(ack), .push_lvl(lvl_q), .push_id(vec_q),
        .pop(handler_ret),
        .top_lvl(top_lvl), .top_id(top_id), .below_lvl(below_lvl),
        .empty(stk_empty), .overflow(stk_ovf)
    );

    logic               do_ret, ret_nmi;
    logic [N_LINES-1:0] ret_mask;

    assign do_ret   = handler_ret && !stk_empty;
    assign ret_nmi  = do_ret && (top_id == VEC_W'(N_LINES));
    assign ret_mask = (do_ret && !ret_nmi) ? (N_LINES'(1) << top_id[LINE_W-1:0]) : '0;

    // Arbitration for a new take.
    logic [N_LINES-1:0] gate;
    logic               hit_t;
    logic [LVL_W-1:0]   lvl_t;
    logic [VEC_W-1:0]   id_t;

    assign gate = line_en & ~{N_LINES{mask_all}};

    irqc_arb #(.N(N_LINES), .PW(PRIO_W), .LW(LVL_W), .VW(VEC_W), .IDLE(IDLE)) u_arb_take (
        .req(pend & gate), .prio(line_prio),
        .nmi_req(nmi_pend_q & ~nmi_act_q),
        .hit(hit_t), .win_lvl(lvl_t), .win_id(id_t)
    );

    // Arbitration against the level restored by a return.
    logic               hit_r;
    logic [LVL_W-1:0]   lvl_r;
    logic [VEC_W-1:0]   id_r;
    logic [N_LINES-1:0] reassert;

    assign reassert = ret_mask & line_trig & src_lvl[N_LINES-1:0];

    irqc_arb #(.N(N_LINES), .PW(PRIO_W), .LW(LVL_W), .VW(VEC_W), .IDLE(IDLE)) u_arb_ret (
        .req((pend | reassert) & gate), .prio(line_prio),
        .nmi_req(nmi_pend_q & (~nmi_act_q | ret_nmi)),
        .hit(hit_r), .win_lvl(lvl_r), .win_id(id_r)
    );

    logic preempt;
    assign preempt = hit_t && (lvl_t < top_lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            tv_q       <= 1'b0;
            vec_q      <= '0;
            lvl_q      <= '0;
            tail_q     <= 1'b0;
            act_q      <= '0;
            nmi_act_q  <= 1'b0;
            nmi_pend_q <= 1'b0;
        end else begin
            if (ack) begin
                tv_q <= 1'b0;
            end else if (!tv_q && preempt) begin
                tv_q  <= 1'b1;
                vec_q <= id_t;
                lvl_q <= lvl_t;
            end
            tail_q     <= do_ret && hit_r && (lvl_r < below_lvl);
            act_q      <= (act_q & ~ret_mask) | ack_mask;
            nmi_act_q  <= (nmi_act_q & ~ret_nmi) | ack_nmi;
            nmi_pend_q <= src_rise[N_LINES] | (nmi_pend_q & ~ack_nmi);
        end
    end

    assign take_valid     = tv_q;
    assign take_vector    = vec_q;
    assign tail_chain     = tail_q;
    assign exec_level     = top_lvl;
    assign stack_overflow = stk_ovf;
    assign pend_status    = pend;
    assign active_status  = act_q;
    assign nmi_active     = nmi_act_q;

    // R10
    take_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (tv_q && !take_ack) |=> (tv_q && $stable(vec_q)));

    // R2
    take_urgent_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tv_q) |-> (lvl_q < top_lvl));

    // R1
    take_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(tv_q) && !vec_is_nmi) |-> $past(line_en[vec_q[LINE_W-1:0]]));

    // R3
    take_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(tv_q) && !vec_is_nmi) |-> !$past(mask_all));

    // R7
    tail_after_ret_chk: assert property (@(posedge clk) disable iff (rst)
        tail_q |-> $past(handler_ret));

endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;
    localparam int PW = 3;
    localparam int SD = 4;
    localparam int IDLE = 9;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NL-1:0]  irq_in = '0;
    logic           nmi_in = 1'b0;
    logic [NL-1:0]  line_en = '1;
    logic [NL-1:0]  line_trig = '0;
    logic [NL*PW-1:0] line_prio;
    logic           mask_all = 1'b0;
    logic [NL-1:0]  pend_clear = '0;
    logic           take_valid;
    logic [4:0]     take_vector;
    logic           take_ack = 1'b0;
    logic           handler_ret = 1'b0;
    logic           tail_chain;
    logic [PW:0]    exec_level;
    logic           stack_overflow;
    logic [NL-1:0]  pend_status;
    logic [NL-1:0]  active_status;
    logic           nmi_active;

    int cfg_p [NL];
    int compared = 0;
    int mismatched = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always_comb begin
        for (int i = 0; i < NL; i++) line_prio[i*PW +: PW] = 3'(cfg_p[i]);
    end

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl #(.N_LINES(NL), .PRIO_W(PW), .STACK_DEPTH(SD), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .nmi_in(nmi_in),
        .line_en(line_en), .line_trig(line_trig), .line_prio(line_prio),
        .mask_all(mask_all), .pend_clear(pend_clear),
        .take_valid(take_valid), .take_vector(take_vector), .take_ack(take_ack),
        .handler_ret(handler_ret), .tail_chain(tail_chain), .exec_level(exec_level),
        .stack_overflow(stack_overflow), .pend_status(pend_status),
        .active_status(active_status), .nmi_active(nmi_active)
    );

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [NL:0]   m_s0, m_s1, m_prev;
    logic [NL-1:0] m_pend, m_act;
    logic          m_npend, m_nact, m_tv, m_tail, m_ovf;
    int            m_vec, m_lvl;
    int            st_lvl[$];
    int            st_id[$];

    function automatic void pick(input logic [NL-1:0] rq, input logic nq,
                                 output int bl, output int bi);
        bl = IDLE; bi = -1;
        if (nq) begin bl = 0; bi = NL; end
        else begin
            for (int i = 0; i < NL; i++)
                if (rq[i] && cfg_p[i] + 1 < bl) begin bl = cfg_p[i] + 1; bi = i; end
        end
    endfunction

    always @(posedge clk) begin : model_step
        logic [NL:0] s, rise;
        logic [NL-1:0] np, na, rq2, gate;
        logic nnp, nna, ack, ret_ok, t;
        int ex, bl, bi, bl2, bi2, post, rid, sz;
        if (rst) begin
            m_s0 = '0; m_s1 = '0; m_prev = '0; m_pend = '0; m_act = '0;
            m_npend = 0; m_nact = 0; m_tv = 0; m_tail = 0; m_ovf = 0;
            m_vec = 0; m_lvl = 0; st_lvl.delete(); st_id.delete();
        end else begin
            s = m_s1; rise = s & ~m_prev;
            sz = st_lvl.size();
            ex = (sz > 0) ? st_lvl[sz-1] : IDLE;
            gate = line_en & ~{NL{mask_all}};
            pick(m_pend & gate, m_npend && !m_nact, bl, bi);
            ack = m_tv && take_ack;
            ret_ok = handler_ret && sz > 0;
            t = 0; rid = 0;
            if (ret_ok) begin
                rid = st_id[sz-1];
                post = (sz >= 2) ? st_lvl[sz-2] : IDLE;
                rq2 = m_pend;
                if (rid < NL && line_trig[rid] && s[rid]) rq2[rid] = 1'b1;
                pick(rq2 & gate, m_npend && (!m_nact || rid == NL), bl2, bi2);
                t = (bi2 >= 0) && (bl2 < post);
            end
            for (int i = 0; i < NL; i++) begin
                if (line_trig[i]) np[i] = s[i] && !m_act[i] && !(ack && m_vec == i);
                else np[i] = rise[i] || (m_pend[i] && !pend_clear[i] && !(ack && m_vec == i));
            end
            nnp = rise[NL] || (m_npend && !(ack && m_vec == NL));
            na = m_act; nna = m_nact;
            if (ret_ok) begin
                if (rid == NL) nna = 0; else na[rid] = 1'b0;
                void'(st_lvl.pop_back()); void'(st_id.pop_back());
            end
            if (ack) begin
                if (m_vec == NL) nna = 1; else na[m_vec] = 1'b1;
                if (st_lvl.size() == SD) m_ovf = 1;
                else begin st_lvl.push_back(m_lvl); st_id.push_back(m_vec); end
            end
            if (ack) m_tv = 0;
            else if (!m_tv && bi >= 0 && bl < ex) begin m_tv = 1; m_vec = bi; m_lvl = bl; end
            m_tail = t; m_pend = np; m_npend = nnp; m_act = na; m_nact = nna;
            m_prev = s; m_s1 = m_s0; m_s0 = {nmi_in, irq_in};
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (!rst && cmp_on && !done) begin
            chk("R2 take_valid", take_valid, m_tv);
            if (m_tv) chk("R8 take_vector", take_vector, m_vec);
            chk("R4 exec_level", exec_level, st_lvl.size() > 0 ? st_lvl[st_lvl.size()-1] : IDLE);
            chk("R7 tail_chain", tail_chain, m_tail);
            chk("R11 stack_overflow", stack_overflow, m_ovf);
            chk("R5 pend_status", pend_status, m_pend);
            chk("R10 active_status", active_status, m_act);
            chk("R3 nmi_active", nmi_active, m_nact);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_irq(input int i);
        irq_in[i] = 1'b1; step(2); irq_in[i] = 1'b0;
    endtask

    task automatic pulse_nmi();
        nmi_in = 1'b1; step(2); nmi_in = 1'b0;
    endtask

    task automatic ack_take(input int exp_vec, input string tag);
        int n = 0;
        while (!take_valid && n < 40) begin step(1); n++; end
        chk({tag, " take offered"}, take_valid, 1);
        chk({tag, " vector"}, take_vector, exp_vec);
        take_ack = 1'b1; step(1); take_ack = 1'b0;
    endtask

    task automatic do_ret();
        handler_ret = 1'b1; step(1); handler_ret = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        compared++; mismatched++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NL; i++) cfg_p[i] = 7;
        step(3);
        rst = 1'b0; cmp_on = 1'b1;
        step(1);
        // R12 reset state
        chk("R12 exec idle", exec_level, IDLE);
        chk("R12 take_valid", take_valid, 0);
        chk("R12 pending", pend_status, 0);
        chk("R12 overflow", stack_overflow, 0);

        // R5 R8: basic edge request
        cfg_p[5] = 4;
        pulse_irq(5);
        ack_take(5, "R8");
        chk("R4 exec after take", exec_level, 5);
        chk("R10 line active", active_status[5], 1);
        do_ret();
        chk("R4 exec back to idle", exec_level, IDLE);

        // R2 R4 R7: equal priority blocked, nesting, tail chain
        cfg_p[9] = 4; cfg_p[2] = 1;
        pulse_irq(5);
        ack_take(5, "R2");
        pulse_irq(9);
        step(10);
        chk("R2 equal level not offered", take_valid, 0);
        chk("R2 equal level pending", pend_status[9], 1);
        pulse_irq(2);
        ack_take(2, "R4");
        chk("R4 nested exec", exec_level, 2);
        do_ret();
        chk("R4 restored exec", exec_level, 5);
        do_ret();
        chk("R7 tail on pending", tail_chain, 1);
        ack_take(9, "R7");
        do_ret();
        chk("R7 no tail when idle", tail_chain, 0);
        step(4);

        // R3: mask versus non-maskable
        mask_all = 1'b1;
        pulse_irq(2);
        step(10);
        chk("R3 masked not offered", take_valid, 0);
        pulse_nmi();
        ack_take(NL, "R3");
        chk("R3 nmi exec level", exec_level, 0);
        do_ret();
        mask_all = 1'b0;
        ack_take(2, "R3");
        do_ret();
        step(4);

        // R1 and R5 clear port
        line_en[7] = 1'b0; cfg_p[7] = 0;
        pulse_irq(7);
        step(10);
        chk("R1 disabled not offered", take_valid, 0);
        chk("R1 disabled still pending", pend_status[7], 1);
        pend_clear[7] = 1'b1; step(1); pend_clear[7] = 1'b0;
        step(1);
        chk("R5 w1c cleared", pend_status[7], 0);
        line_en[7] = 1'b1;
        step(10);
        chk("R1 nothing after clear", take_valid, 0);

        // R9: tie on equal priority
        cfg_p[11] = 3; cfg_p[12] = 3;
        irq_in[11] = 1'b1; irq_in[12] = 1'b1; step(2);
        irq_in[11] = 1'b0; irq_in[12] = 1'b0;
        ack_take(11, "R9");
        do_ret();
        chk("R9 tail for other tie", tail_chain, 1);
        ack_take(12, "R9");
        do_ret();
        step(4);

        // R6: level line re-entry
        line_trig[4] = 1'b1; cfg_p[4] = 2;
        irq_in[4] = 1'b1;
        ack_take(4, "R6");
        step(5);
        do_ret();
        chk("R6 tail on reassert", tail_chain, 1);
        ack_take(4, "R6");
        irq_in[4] = 1'b0;
        step(5);
        do_ret();
        chk("R6 no tail after drop", tail_chain, 0);
        step(10);
        chk("R6 no reentry after drop", take_valid, 0);
        chk("R6 not pending", pend_status[4], 0);
        line_trig[4] = 1'b0;

        // R11: overflow with a four-deep stack
        cfg_p[0] = 6; cfg_p[1] = 5; cfg_p[2] = 4; cfg_p[3] = 3;
        for (int k = 0; k < 4; k++) begin
            pulse_irq(k);
            ack_take(k, "R11");
        end
        chk("R11 no overflow yet", stack_overflow, 0);
        pulse_nmi();
        ack_take(NL, "R11");
        chk("R11 overflow set", stack_overflow, 1);
        chk("R11 exec unchanged", exec_level, 4);
        for (int k = 0; k < 4; k++) do_ret();
        chk("R11 overflow sticky", stack_overflow, 1);
        chk("R4 exec idle after unwind", exec_level, IDLE);
        step(5);

        finish_run();
    end

endmodule